// File: doc/BRIEF.md
# Range-Based Chip-Select and Chip-Enable Decoder

This block sits between the slave port of a processor bus and a bank of user registers. It turns each bus address into select lines. A parameter table lists address windows, each given by an inclusive base and high byte address. A sampled access whose address falls inside a window raises that window's chip-select.

Each window is also cut into a configured number of equal slices. Each slice drives one bit of a read chip-enable vector and one bit of a write chip-enable vector. All windows share these two vectors. A slice usually maps to a single 32-bit register, so user logic can pick its register from one enable bit and needs no address compare of its own.

An access that hits no window raises an unmapped flag instead of any select. All decode results are registered. The bus handshake, data steering and byte lanes stay outside the block.

Window sizes must be powers of two and aligned to their base. Windows must not overlap. Each slice count must be a power of two no larger than its window. The enable width must equal the sum of the slice counts. The block stops at elaboration if any of these limits is broken.

Top module: `rangeCsDecoder`

## Requirements
- R1: An access sampled with `busValid` high whose byte address lies between a window's base and high address (both included) raises that window's `chipSel` bit, for reads and writes alike. At most one `chipSel` bit is ever high.
- R2: Enable bits are numbered by joining the windows in table order, with window 0 taking the lowest indices. With the default table, window 0 is 0x1000..0x107F with 8 enables (bits 0..7), and window 1 is 0x2000..0x200F with 4 enables (bits 8..11).
- R3: Within a window, each enable covers window size / enable count bytes. The enable index is (address - base) shifted right by log2 of that slice size, so the lowest slice maps to the lowest index. For example, 0x1035 selects bit 3 and 0x200F selects bit 11.
- R4: `wrCe` is one-hot or zero. It is non-zero only for an access sampled with `busRnw` = 0.
- R5: `rdCe` is non-zero only for an access sampled with `busRnw` = 1. `rdCe` and `wrCe` are never both non-zero.
- R6: An access to an address in no window leaves `chipSel`, `rdCe` and `wrCe` at zero and raises `unmapped`. `unmapped` is high for exactly the one cycle after each such access.
- R7: Outputs change one clock after the inputs are sampled. A cycle with `busValid` low gives all-zero outputs on the next cycle, whatever the address.
- R8: Synchronous reset clears every output. Reset wins over an access sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | ADDR_W | Byte address of the access |
| busValid | input | 1 | Access strobe |
| busRnw | input | 1 | 1 = read, 0 = write |
| chipSel | output | NUM_WIN | Registered per-window select |
| rdCe | output | NUM_CE | Registered one-hot read enables |
| wrCe | output | NUM_CE | Registered one-hot write enables |
| unmapped | output | 1 | One-cycle pulse for an access outside every window |

## Verification
Reset and a valid access can land on the same clock edge. Only reset may show on the outputs in that case. The bench holds `busValid` high with an in-window write address while `rst` is high for one edge. It then checks that the select, both enable vectors and the unmapped flag all read zero. The next access must decode normally. Back-to-back accesses where an unmapped hit is followed at once by a mapped one check that the flag clears in the same cycle the new enable rises.

// File: rtl/decPkg.sv
package decPkg;

  // Strobes that the control half hands to the datapath each cycle.
  typedef struct packed {
    logic anyEn;  // access sampled this cycle
    logic rdEn;   // sampled access is a read
    logic wrEn;   // sampled access is a write
  } decStrobes_t;

endpackage

// File: rtl/decCtrl.sv
module decCtrl
  import decPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busValid,
  input  logic        busRnw,
  input  logic        anyHit,
  output decStrobes_t strobes,
  output logic        unmapped
);

  always_comb begin
    strobes.anyEn = busValid;
    strobes.rdEn  = busValid & busRnw;
    strobes.wrEn  = busValid & ~busRnw;
  end

  // One pulse per sampled access that misses every window.
  always_ff @(posedge clk) begin
    if (rst) unmapped <= 1'b0;
    else     unmapped <= busValid & ~anyHit;
  end

endmodule

// File: rtl/decDatapath.sv
module decDatapath
  import decPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int NUM_CE  = 12,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE   = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HIGH   = '0,
  parameter logic [NUM_WIN-1:0][7:0]        WIN_CE_CNT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  decStrobes_t        strobes,
  output logic               anyHit,
  output logic [NUM_WIN-1:0] chipSel,
  output logic [NUM_CE-1:0]  rdCe,
  output logic [NUM_CE-1:0]  wrCe
);

  // First enable index owned by window w.
  function automatic int ceOffset(input int w);
    int s;
    s = 0;
    for (int i = 0; i < w; i++) s += int'(WIN_CE_CNT[i]);
    return s;
  endfunction

  logic [NUM_WIN-1:0] winHit;
  logic [NUM_CE-1:0]  ceHit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W:0] SIZE =
      {1'b0, WIN_HIGH[w]} - {1'b0, WIN_BASE[w]} + 1'b1;
    localparam int CNT      = int'(WIN_CE_CNT[w]);
    localparam int SLICE_SH = $clog2(SIZE) - $clog2(CNT);
    localparam int OFF      = ceOffset(w);

    // Elaboration-time limits on the window table.
    if ((SIZE & (SIZE - 1'b1)) != '0) begin : g_badSize
      $error("window %0d size is not a power of two", w);
    end
    if (({1'b0, WIN_BASE[w]} & (SIZE - 1'b1)) != '0) begin : g_badAlign
      $error("window %0d base is not aligned to its size", w);
    end
    if (CNT < 1 || (CNT & (CNT - 1)) != 0 || CNT > SIZE) begin : g_badCnt
      $error("window %0d enable count is invalid", w);
    end
    for (genvar v = w + 1; v < NUM_WIN; v++) begin : g_ovl
      if (!(WIN_HIGH[w] < WIN_BASE[v] || WIN_HIGH[v] < WIN_BASE[w])) begin : g_bad
        $error("windows %0d and %0d overlap", w, v);
      end
    end

    logic [ADDR_W-1:0] winOfs;
    logic [ADDR_W-1:0] sliceIdx;

    always_comb begin
      winHit[w] = (addr >= WIN_BASE[w]) && (addr <= WIN_HIGH[w]);
      winOfs    = addr - WIN_BASE[w];
      sliceIdx  = winOfs >> SLICE_SH;
    end

    for (genvar k = 0; k < CNT; k++) begin : g_slice
      assign ceHit[OFF + k] = winHit[w] && (sliceIdx == ADDR_W'(k));
    end
  end

  assign anyHit = |winHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      chipSel <= '0;
      rdCe    <= '0;
      wrCe    <= '0;
    end else begin
      chipSel <= strobes.anyEn ? winHit : '0;
      rdCe    <= strobes.rdEn  ? ceHit  : '0;
      wrCe    <= strobes.wrEn  ? ceHit  : '0;
    end
  end

endmodule

// File: rtl/rangeCsDecoder.sv
module rangeCsDecoder
  import decPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int NUM_CE  = 12,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE =
    {32'h0000_2000, 32'h0000_1000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HIGH =
    {32'h0000_200F, 32'h0000_107F},
  parameter logic [NUM_WIN-1:0][7:0] WIN_CE_CNT = {8'd4, 8'd8}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busValid,
  input  logic               busRnw,
  output logic [NUM_WIN-1:0] chipSel,
  output logic [NUM_CE-1:0]  rdCe,
  output logic [NUM_CE-1:0]  wrCe,
  output logic               unmapped
);

  function automatic int ceTotal();
    int s;
    s = 0;
    for (int i = 0; i < NUM_WIN; i++) s += int'(WIN_CE_CNT[i]);
    return s;
  endfunction

  localparam int CE_SUM = ceTotal();

  if (CE_SUM != NUM_CE) begin : g_badTotal
    $error("NUM_CE does not match the sum of window enable counts");
  end

  decStrobes_t strobes;
  logic        anyHit;

  decCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busValid (busValid),
    .busRnw   (busRnw),
    .anyHit   (anyHit),
    .strobes  (strobes),
    .unmapped (unmapped)
  );

  decDatapath #(
    .ADDR_W     (ADDR_W),
    .NUM_WIN    (NUM_WIN),
    .NUM_CE     (NUM_CE),
    .WIN_BASE   (WIN_BASE),
    .WIN_HIGH   (WIN_HIGH),
    .WIN_CE_CNT (WIN_CE_CNT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .addr    (busAddr),
    .strobes (strobes),
    .anyHit  (anyHit),
    .chipSel (chipSel),
    .rdCe    (rdCe),
    .wrCe    (wrCe)
  );

endmodule

// File: rtl/decChk.sv
module decChk #(
  parameter int NUM_WIN = 2,
  parameter int NUM_CE  = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               busValid,
  input logic               busRnw,
  input logic [NUM_WIN-1:0] chipSel,
  input logic [NUM_CE-1:0]  rdCe,
  input logic [NUM_CE-1:0]  wrCe,
  input logic               unmapped
);

  p_one_window_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chipSel));

  p_enable_inside_window_r2: assert property (@(posedge clk) disable iff (rst)
    (|rdCe || |wrCe) |-> (|chipSel));

  p_wr_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wrCe));

  p_wr_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    (|wrCe) |-> ($past(busValid) && !$past(busRnw)));

  p_rd_needs_read_r5: assert property (@(posedge clk) disable iff (rst)
    (|rdCe) |-> ($past(busValid) && $past(busRnw)));

  p_rd_wr_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !((|rdCe) && (|wrCe)));

  p_unmapped_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (chipSel == '0 && rdCe == '0 && wrCe == '0));

  p_idle_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(busValid) |-> (chipSel == '0 && rdCe == '0 && wrCe == '0 && !unmapped));

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chipSel == '0 && rdCe == '0 && wrCe == '0 && !unmapped));

endmodule

bind rangeCsDecoder decChk #(
  .NUM_WIN (NUM_WIN),
  .NUM_CE  (NUM_CE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busValid (busValid),
  .busRnw   (busRnw),
  .chipSel  (chipSel),
  .rdCe     (rdCe),
  .wrCe     (wrCe),
  .unmapped (unmapped)
);

// File: tb/sim_rangeCsDecoder.sv
module sim_rangeCsDecoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] busAddr = '0;
  logic        busValid = 1'b0;
  logic        busRnw = 1'b0;
  logic [1:0]  chipSel;
  logic [11:0] rdCe;
  logic [11:0] wrCe;
  logic        unmapped;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  rangeCsDecoder u0 (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busValid (busValid),
    .busRnw   (busRnw),
    .chipSel  (chipSel),
    .rdCe     (rdCe),
    .wrCe     (wrCe),
    .unmapped (unmapped)
  );

  task automatic checkOut(input string req, input logic [1:0] eCs,
                          input logic [11:0] eRd, input logic [11:0] eWr,
                          input logic eUn);
    total++;
    if (chipSel !== eCs || rdCe !== eRd || wrCe !== eWr || unmapped !== eUn) begin
      bad++;
      $display("FAIL %s: cs=%b rd=%h wr=%h un=%b expected cs=%b rd=%h wr=%h un=%b",
               req, chipSel, rdCe, wrCe, unmapped, eCs, eRd, eWr, eUn);
    end
  endtask

  // Drive one cycle at the falling edge, then sample just after the rising edge.
  task automatic drive(input logic [31:0] a, input logic v, input logic r);
    @(negedge clk);
    busAddr  = a;
    busValid = v;
    busRnw   = r;
    @(posedge clk);
    #1;
  endtask

  // Expected decode from the requirement table (R2, R3).
  task automatic expectFor(input logic [31:0] a, input logic r, input string req);
    logic [1:0]  eCs;
    logic [11:0] eCe;
    logic        eUn;
    eCs = '0; eCe = '0; eUn = 1'b0;
    if (a >= 32'h1000 && a <= 32'h107F) begin
      eCs = 2'b01;
      eCe = 12'(1) << ((a - 32'h1000) >> 4);
    end else if (a >= 32'h2000 && a <= 32'h200F) begin
      eCs = 2'b10;
      eCe = 12'(1) << (8 + ((a - 32'h2000) >> 2));
    end else begin
      eUn = 1'b1;
    end
    checkOut(req, eCs, r ? eCe : '0, r ? '0 : eCe, eUn);
  endtask

  task automatic testReset();
    drive(32'h1000, 1'b0, 1'b0);
    checkOut("R8 reset state", '0, '0, '0, 1'b0);
  endtask

  task automatic testWindow0Writes();
    drive(32'h1000, 1'b1, 1'b0);
    checkOut("R1 R4 write base", 2'b01, '0, 12'h001, 1'b0);
    drive(32'h107F, 1'b1, 1'b0);
    checkOut("R3 write top", 2'b01, '0, 12'h080, 1'b0);
  endtask

  task automatic testReads();
    drive(32'h1035, 1'b1, 1'b1);
    checkOut("R3 R5 read 0x1035", 2'b01, 12'h008, '0, 1'b0);
    drive(32'h200F, 1'b1, 1'b1);
    checkOut("R2 R5 read 0x200F", 2'b10, 12'h800, '0, 1'b0);
  endtask

  task automatic testWindow1Writes();
    drive(32'h2000, 1'b1, 1'b0);
    checkOut("R2 write 0x2000", 2'b10, '0, 12'h100, 1'b0);
    drive(32'h2004, 1'b1, 1'b0);
    checkOut("R3 write 0x2004", 2'b10, '0, 12'h200, 1'b0);
  endtask

  task automatic testSweep();
    for (int a = 32'h0FFC; a <= 32'h1083; a++) begin
      drive(32'(a), 1'b1, a[0]);
      expectFor(32'(a), a[0], "R3 sweep window0");
    end
    for (int a = 32'h1FFE; a <= 32'h2011; a++) begin
      drive(32'(a), 1'b1, a[1]);
      expectFor(32'(a), a[1], "R2 sweep window1");
    end
  endtask

  task automatic testUnmapped();
    drive(32'h1080, 1'b1, 1'b0);
    checkOut("R6 unmapped 0x1080", '0, '0, '0, 1'b1);
    drive(32'h1080, 1'b0, 1'b0);
    checkOut("R6 unmapped one cycle", '0, '0, '0, 1'b0);
    drive(32'h0FFF, 1'b1, 1'b1);
    checkOut("R6 unmapped 0x0FFF", '0, '0, '0, 1'b1);
    drive(32'h1010, 1'b1, 1'b0);
    checkOut("R6 flag clears on hit", 2'b01, '0, 12'h002, 1'b0);
  endtask

  task automatic testIdle();
    drive(32'h1020, 1'b0, 1'b0);
    checkOut("R7 idle in-window", '0, '0, '0, 1'b0);
    drive(32'h3000, 1'b0, 1'b1);
    checkOut("R7 idle out-of-window", '0, '0, '0, 1'b0);
  endtask

  task automatic testBackToBack();
    drive(32'h1010, 1'b1, 1'b0);
    checkOut("R7 b2b first", 2'b01, '0, 12'h002, 1'b0);
    drive(32'h2008, 1'b1, 1'b1);
    checkOut("R7 b2b second", 2'b10, 12'h400, '0, 1'b0);
  endtask

  task automatic testResetWithAccess();
    @(negedge clk);
    rst = 1'b1;
    busAddr = 32'h1040;
    busValid = 1'b1;
    busRnw = 1'b0;
    @(posedge clk);
    #1;
    checkOut("R8 reset beats access", '0, '0, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    checkOut("R8 access after reset", 2'b01, '0, 12'h010, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testWindow0Writes();
    testReads();
    testWindow1Writes();
    testUnmapped();
    testIdle();
    testBackToBack();
    testSweep();
    testResetWithAccess();
    drive(32'h0, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule